// File: doc/BRIEF.md
# Burst-of-Two Double-Data-Rate SRAM Port

This block is the synchronous front end and storage of a common-I/O SRAM that moves data on both edges of one clock. Each access is a fixed burst of two words. A start strobe, a direction bit and a word address are taken on the rising edge of `clk_k`. Write data then arrives on the next rising edge and on the falling edge after it. Read data leaves the port on a rising edge and on the falling edge after it. The falling edge stands in for the complementary clock, so the block runs in single-clock mode.

The storage is split into two halves of equal depth. Each half holds one word of every pair. The lowest address bit is a one-bit burst counter. The first beat goes to the addressed word. The second beat goes to the word whose lowest bit is the first plus one, modulo two. Each lane of a word has its own active-low write select, taken with the beat it qualifies. A lane is nine bits wide for byte-plus-parity variants and four bits wide for a nibble variant.

Data moves on a fixed schedule. There is no valid/ready pairing and no back-pressure: the port never stalls and a beat cannot be refused. The start strobe is the only qualifier on the input side. `q_oe` is the only qualifier on the output side. While `q_oe` is low, the data outputs are to be treated as high impedance.

Top module: `ddrb2_sram`

## Requirements
- R1: A burst begins only when `start_n` is 0 at a rising edge of `clk_k`. That edge latches `addr` and `is_rd`: 1 selects a read, 0 selects a write.
- R2: Every burst moves two words at the same upper address bits. The first word is at the loaded address A. The second is at A with its lowest bit incremented modulo two, so a burst loaded at an odd address wraps to the even word.
- R3: For a write loaded at rising edge n, beat one is taken from `d_in` at rising edge n+1. Beat two is taken at the falling edge that follows it.
- R4: Each beat has its own `lane_wr_n`, taken on the same edge as its data. Bit l covers `d_in[l*LANE_W +: LANE_W]`; with the defaults, bit 0 covers [8:0] and bit 1 covers [17:9]. A lane whose select is 1 keeps its stored bits.
- R5: For a read loaded at rising edge n (with `RD_LAT` = 1), word one is driven on `q_out` from rising edge n+RD_LAT. Word two is driven from the falling edge that follows it.
- R6: `q_oe` is 1 for exactly the `clk_k` period in which a read's two words are on `q_out`, and 0 otherwise. While it is 0, `q_out` is all zeros.
- R7: At a rising edge where `start_n` is 1, `is_rd`, `addr`, `d_in` and `lane_wr_n` change no stored word and start no read. A burst already under way still completes its second beat.
- R8: A read loaded on the rising edge right after a write's load edge, at the same address, returns the newly written words.
- R9: While `rst` is 1, `q_oe` and `q_out` are 0 and no burst is pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_k | input | 1 | Data clock; rising edge and falling edge both used |
| rst | input | 1 | Synchronous active-high reset of control state |
| start_n | input | 1 | Active-low burst start strobe |
| is_rd | input | 1 | Direction for a started burst: 1 read, 0 write |
| addr | input | ADDR_W | Word address; bit 0 seeds the burst counter |
| d_in | input | LANE_W*LANES | Write data, one beat per clock edge |
| lane_wr_n | input | LANES | Active-low per-lane write selects, one set per beat |
| q_out | output | LANE_W*LANES | Read data, one word per clock edge |
| q_oe | output | 1 | Output enable for the read data pads |

## Verification
The second write beat is committed on a falling edge. A read loaded on the very next rising edge captures its words at the following rising edge. A write-then-read pair to one address therefore commits and fetches the same word within half a period. The bench issues such pairs back to back and also chains write, write, read. Each read must return the merged words of the preceding write, and `q_oe` must cover exactly one period per read.

// File: rtl/ddrb2_pkg.sv
`timescale 1ns/1ps
package ddrb2_pkg;
  typedef enum logic {
    OP_WR = 1'b0,
    OP_RD = 1'b1
  } ddrb2_op_e;
endpackage

// File: rtl/ddrb2_cmd.sv
`timescale 1ns/1ps
module ddrb2_cmd
  import ddrb2_pkg::*;
#(
  parameter int ADDR_W = 4,
  parameter int RD_LAT = 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start_n,
  input  logic              is_rd,
  input  logic [ADDR_W-1:0] addr,
  output logic              wr_pend,
  output logic [ADDR_W-1:0] wr_addr,
  output logic              rd_go,
  output logic [ADDR_W-1:0] rd_addr
);
  ddrb2_op_e op;
  logic      ld_wr, ld_rd;
  logic [RD_LAT-1:0] rd_vld;
  logic [ADDR_W-1:0] rd_pipe [RD_LAT];

  assign op    = ddrb2_op_e'(is_rd);
  assign ld_wr = !start_n && (op == OP_WR);
  assign ld_rd = !start_n && (op == OP_RD);

  always_ff @(posedge clk) begin
    if (rst) wr_pend <= 1'b0;
    else     wr_pend <= ld_wr;
  end

  always_ff @(posedge clk) begin
    if (ld_wr) wr_addr <= addr;
  end

  if (RD_LAT == 1) begin : g_lat_one
    always_ff @(posedge clk) begin
      if (rst) rd_vld[0] <= 1'b0;
      else     rd_vld[0] <= ld_rd;
      if (ld_rd) rd_pipe[0] <= addr;
    end
  end else begin : g_lat_many
    always_ff @(posedge clk) begin
      if (rst) rd_vld <= '0;
      else     rd_vld <= {rd_vld[RD_LAT-2:0], ld_rd};
    end
    always_ff @(posedge clk) begin
      if (ld_rd) rd_pipe[0] <= addr;
      for (int s = 1; s < RD_LAT; s++) rd_pipe[s] <= rd_pipe[s-1];
    end
  end

  assign rd_go   = rd_vld[RD_LAT-1];
  assign rd_addr = rd_pipe[RD_LAT-1];

  // R1
  dir_excl_chk: assert property (@(posedge clk) disable iff (rst)
    !(wr_pend && rd_vld[0]));

  // R7
  idle_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    start_n |=> (!wr_pend && !rd_vld[0]));
endmodule

// File: rtl/ddrb2_wcap.sv
`timescale 1ns/1ps
module ddrb2_wcap #(
  parameter int ADDR_W = 4,
  parameter int DATA_W = 18,
  parameter int LANES  = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_pend,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] d_in,
  input  logic [LANES-1:0]  lane_wr_n,
  output logic              arm,
  output logic [ADDR_W-1:0] arm_addr,
  output logic [DATA_W-1:0] b0_data,
  output logic [LANES-1:0]  b0_mask_n
);
  always_ff @(posedge clk) begin
    if (rst) arm <= 1'b0;
    else     arm <= wr_pend;
  end

  always_ff @(posedge clk) begin
    if (wr_pend) begin
      b0_data   <= d_in;
      b0_mask_n <= lane_wr_n;
      arm_addr  <= wr_addr;
    end
  end

  // R3
  beat_arm_chk: assert property (@(posedge clk) disable iff (rst)
    wr_pend |=> arm);
endmodule

// File: rtl/ddrb2_half.sv
`timescale 1ns/1ps
module ddrb2_half #(
  parameter int ROW_W  = 3,
  parameter int LANE_W = 9,
  parameter int LANES  = 2
) (
  input  logic                    clk,
  input  logic                    we,
  input  logic [ROW_W-1:0]        wrow,
  input  logic [LANE_W*LANES-1:0] wdata,
  input  logic [LANES-1:0]        wmask_n,
  input  logic [ROW_W-1:0]        rrow,
  output logic [LANE_W*LANES-1:0] rdata
);
  localparam int DATA_W = LANE_W * LANES;
  localparam int ROWS   = 1 << ROW_W;

  logic [DATA_W-1:0] mem [ROWS];

  always_ff @(negedge clk) begin
    if (we) begin
      for (int l = 0; l < LANES; l++) begin
        if (!wmask_n[l]) mem[wrow][l*LANE_W +: LANE_W] <= wdata[l*LANE_W +: LANE_W];
      end
    end
  end

  assign rdata = mem[rrow];
endmodule

// File: rtl/ddrb2_rdout.sv
`timescale 1ns/1ps
module ddrb2_rdout #(
  parameter int DATA_W = 18
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              rd_go,
  input  logic [DATA_W-1:0] beat0,
  input  logic [DATA_W-1:0] beat1,
  output logic [DATA_W-1:0] q_out,
  output logic              q_oe
);
  logic              oe_r;
  logic [DATA_W-1:0] q_rise, hold, q_fall;

  always_ff @(posedge clk) begin
    if (rst) begin
      oe_r   <= 1'b0;
      q_rise <= '0;
      hold   <= '0;
    end else begin
      oe_r   <= rd_go;
      q_rise <= rd_go ? beat0 : '0;
      hold   <= rd_go ? beat1 : '0;
    end
  end

  always_ff @(negedge clk) begin
    if (rst)  q_fall <= '0;
    else      q_fall <= oe_r ? hold : '0;
  end

  assign q_out = clk ? q_rise : q_fall;
  assign q_oe  = oe_r;

  // R5
  fire_oe_chk: assert property (@(posedge clk) disable iff (rst)
    rd_go |=> oe_r);

  // R6
  idle_oe_chk: assert property (@(posedge clk) disable iff (rst)
    !rd_go |=> (!oe_r && (q_rise == '0)));
endmodule

// File: rtl/ddrb2_sram.sv
`timescale 1ns/1ps
module ddrb2_sram #(
  parameter int ADDR_W = 4,
  parameter int LANE_W = 9,
  parameter int LANES  = 2,
  parameter int RD_LAT = 1
) (
  input  logic                    clk_k,
  input  logic                    rst,
  input  logic                    start_n,
  input  logic                    is_rd,
  input  logic [ADDR_W-1:0]       addr,
  input  logic [LANE_W*LANES-1:0] d_in,
  input  logic [LANES-1:0]        lane_wr_n,
  output logic [LANE_W*LANES-1:0] q_out,
  output logic                    q_oe
);
  localparam int DATA_W = LANE_W * LANES;
  localparam int ROW_W  = ADDR_W - 1;

  logic              wr_pend, rd_go, w_arm, rd_nxt;
  logic [ADDR_W-1:0] wr_addr, rd_addr, w_addr;
  logic [DATA_W-1:0] b0_data, beat0, beat1;
  logic [LANES-1:0]  b0_mask_n;
  logic [DATA_W-1:0] half_rd [2];

  ddrb2_cmd #(.ADDR_W(ADDR_W), .RD_LAT(RD_LAT)) u_cmd (
    .clk(clk_k), .rst(rst), .start_n(start_n), .is_rd(is_rd), .addr(addr),
    .wr_pend(wr_pend), .wr_addr(wr_addr), .rd_go(rd_go), .rd_addr(rd_addr)
  );

  ddrb2_wcap #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .LANES(LANES)) u_wcap (
    .clk(clk_k), .rst(rst), .wr_pend(wr_pend), .wr_addr(wr_addr),
    .d_in(d_in), .lane_wr_n(lane_wr_n), .arm(w_arm), .arm_addr(w_addr),
    .b0_data(b0_data), .b0_mask_n(b0_mask_n)
  );

  for (genvar h = 0; h < 2; h++) begin : g_half
    logic              sel_b0;
    logic [DATA_W-1:0] wdat;
    logic [LANES-1:0]  wmsk;
    assign sel_b0 = (w_addr[0] == 1'(h));
    assign wdat   = sel_b0 ? b0_data   : d_in;
    assign wmsk   = sel_b0 ? b0_mask_n : lane_wr_n;
    ddrb2_half #(.ROW_W(ROW_W), .LANE_W(LANE_W), .LANES(LANES)) u_half (
      .clk(clk_k), .we(w_arm), .wrow(w_addr[ADDR_W-1:1]), .wdata(wdat),
      .wmask_n(wmsk), .rrow(rd_addr[ADDR_W-1:1]), .rdata(half_rd[h])
    );
  end

  assign rd_nxt = rd_addr[0] + 1'b1;
  assign beat0  = half_rd[rd_addr[0]];
  assign beat1  = half_rd[rd_nxt];

  ddrb2_rdout #(.DATA_W(DATA_W)) u_rdout (
    .clk(clk_k), .rst(rst), .rd_go(rd_go), .beat0(beat0), .beat1(beat1),
    .q_out(q_out), .q_oe(q_oe)
  );
endmodule

// File: tb/test_ddrb2_sram.sv
`timescale 1ns/1ps
module test_ddrb2_sram;
  localparam int AW = 4, LW = 9, NL = 2, DW = LW * NL, WORDS = 1 << AW;

  logic clk = 1'b0, rst = 1'b1, start_n = 1'b1, is_rd = 1'b0;
  logic [AW-1:0] addr = '0;
  logic [DW-1:0] d_in = '0;
  logic [NL-1:0] lane_wr_n = '1;
  logic [DW-1:0] q_out;
  logic          q_oe;

  always #2.5 clk = ~clk;

  ddrb2_sram #(.ADDR_W(AW), .LANE_W(LW), .LANES(NL), .RD_LAT(1)) i_ddrb2_sram (
    .clk_k(clk), .rst(rst), .start_n(start_n), .is_rd(is_rd), .addr(addr),
    .d_in(d_in), .lane_wr_n(lane_wr_n), .q_out(q_out), .q_oe(q_oe)
  );

  int checks = 0, fails = 0;
  logic [DW-1:0] ref_mem [WORDS];
  logic [DW-1:0] q_hi, q_lo, exp0, exp1;
  logic oe_hi, oe_lo, exp_v = 1'b0, wr_v = 1'b0;
  logic [AW-1:0] wr_a;
  string exp_tag;

  task automatic chk(string tag, logic [DW-1:0] act, logic [DW-1:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [DW-1:0] merge(logic [DW-1:0] old, logic [DW-1:0] nw, logic [NL-1:0] m);
    logic [DW-1:0] r = old;
    for (int l = 0; l < NL; l++) if (!m[l]) r[l*LW +: LW] = nw[l*LW +: LW];
    return r;
  endfunction

  function automatic logic [DW-1:0] pat(int a, int k);
    return DW'((a + 1) * 32'h29A3B + k * 32'h11111 + 7);
  endfunction

  function automatic logic [AW-1:0] mate(logic [AW-1:0] a);
    return {a[AW-1:1], ~a[0]};
  endfunction

  // One clk_k period: load fields and first-beat data before the rising edge,
  // second-beat data before the falling edge; outputs sampled 1 ns after each edge.
  task automatic step(logic l, logic r, logic [AW-1:0] a, logic [DW-1:0] dr, logic [NL-1:0] mr,
                      logic [DW-1:0] df, logic [NL-1:0] mf, string tag);
    start_n = l; is_rd = r; addr = a; d_in = dr; lane_wr_n = mr;
    @(posedge clk); #1;
    oe_hi = q_oe; q_hi = q_out;
    start_n = 1'b1; is_rd = ~r; addr = ~a; d_in = df; lane_wr_n = mf;
    @(negedge clk); #1;
    oe_lo = q_oe; q_lo = q_out;
    if (exp_v) begin
      chk($sformatf("%s/R5 first word", exp_tag), q_hi, exp0);
      chk($sformatf("%s/R2 second word", exp_tag), q_lo, exp1);
      chk("R6 enable during read", DW'({oe_hi, oe_lo}), DW'(2'b11));
    end else begin
      chk("R6 enable low while idle", DW'({oe_hi, oe_lo}), '0);
      chk("R6 bus zero while idle", q_hi | q_lo, '0);
    end
    if (wr_v) begin
      ref_mem[wr_a]       = merge(ref_mem[wr_a], dr, mr);
      ref_mem[mate(wr_a)] = merge(ref_mem[mate(wr_a)], df, mf);
    end
    wr_v = !l && !r;
    wr_a = a;
    exp_v = !l && r;
    if (exp_v) begin
      exp0 = ref_mem[a];
      exp1 = ref_mem[mate(a)];
      exp_tag = tag;
    end
  endtask

  task automatic idle();
    step(1'b1, 1'b0, '0, '0, '1, '0, '1, "idle");
  endtask

  task automatic wr(logic [AW-1:0] a, logic [DW-1:0] w0, logic [NL-1:0] m0,
                    logic [DW-1:0] w1, logic [NL-1:0] m1);
    step(1'b0, 1'b0, a, '0, '1, '0, '1, "wr");
    step(1'b1, 1'b0, '0, w0, m0, w1, m1, "wr");
  endtask

  task automatic rd(logic [AW-1:0] a, string tag);
    step(1'b0, 1'b1, a, '0, '1, '0, '1, tag);
  endtask

  initial begin
    for (int i = 0; i < WORDS; i++) ref_mem[i] = '0;
    repeat (4) @(posedge clk);
    @(negedge clk); #1;
    chk("R9 enable in reset", DW'(q_oe), '0);
    chk("R9 bus in reset", q_out, '0);
    rst = 1'b0;

    // Fill every pair with all lanes enabled (R3 beat order)
    for (int a = 0; a < WORDS; a += 2) wr(AW'(a), pat(a, 0), '0, pat(a, 1), '0);
    idle();
    // Pipelined readback from every start address: even (R1), odd wraps (R2)
    for (int a = 0; a < WORDS; a++) rd(AW'(a), a % 2 == 1 ? "R2" : "R1");
    idle();

    // Odd load address: first beat to the odd word, second wraps to even (R3)
    wr(AW'(5), pat(40, 2), '0, pat(41, 3), '0);
    rd(AW'(5), "R3");
    rd(AW'(4), "R3");
    idle();

    // Every per-beat lane mask combination on every row, both burst starts (R4)
    for (int r = 0; r < WORDS / 2; r++)
      for (int m0 = 0; m0 < (1 << NL); m0++)
        for (int m1 = 0; m1 < (1 << NL); m1++) begin
          logic [AW-1:0] a;
          a = {AW'(r)} << 1 | AW'((m0 + m1) % 2);
          wr(a, pat(r * 16 + m0 * 4 + m1, 5), NL'(m0), pat(r * 16 + m0 * 4 + m1, 6), NL'(m1));
          rd(a, "R4");
        end
    idle();

    // Read loaded on the edge right after a write load, same address (R8)
    for (int a = 0; a < WORDS; a += 3) begin
      step(1'b0, 1'b0, AW'(a), '0, '1, '0, '1, "R8");
      step(1'b0, 1'b1, AW'(a), pat(a, 9), '0, pat(a, 10), 2'b01, "R8");
    end
    step(1'b0, 1'b0, AW'(2), '0, '1, '0, '1, "R8");
    step(1'b0, 1'b0, AW'(9), pat(70, 1), '0, pat(70, 2), '0, "R8");
    step(1'b0, 1'b1, AW'(2), pat(71, 1), 2'b10, pat(71, 2), '0, "R8");
    rd(AW'(9), "R8");
    idle();

    // Start strobe high: junk direction, address, data and enabled lanes ignored (R7)
    for (int i = 0; i < 16; i++)
      step(1'b1, i[0], AW'(i), pat(100 + i, 0), '0, pat(100 + i, 1), '0, "R7");
    for (int a = 0; a < WORDS; a++) rd(AW'(a), "R7");
    idle();
    idle();

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    #(200000 * 5);
    fails++;
    $display("FAIL watchdog (all requirements) actual=running expected=finished");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule